// File: doc/BRIEF.md
# DDR Bank Command Timing Checker

This block watches the command bus between a DDR SDRAM controller and a four-bank memory device. It decodes each clock's command from the strobe and address pins and keeps a model of which banks are open. It also runs counters for the per-bank delays (open-to-column, open-to-close, close-to-open) and for the delays between banks and after mode programming. When a command comes too early, or targets a bank in the wrong state, the block raises a single-cycle flag together with a code that says which rule was broken. It is a passive observer for simulation monitors or on-chip protocol guards.

The timing limits are parameters counted in clock cycles. The closing delay for column commands with auto-close equals the burst's command-side length plus the read latency. A flagged command still updates the bank model as though the memory had taken it, so one mistake does not turn into a stream of follow-on reports.

Top module: `ddr_cmd_guard`

## Requirements
- R1: A cycle with `cmd_sel_n` high is a deselect, and a cycle with `cmd_sel_n` low and `cmd_row_n`, `cmd_col_n` and `cmd_wr_n` all high is a no-op. Neither one is ever flagged, and neither changes any bank or timer state.
- R2: The flag `err_pulse` is high for exactly the cycle after an offending command is sampled, and `err_code` carries the cause in that cycle. `err_code` is 0 whenever `err_pulse` is low, including right after reset. The codes are: 1 DLL lock wait, 2 mode-set gap, 3 mode set with an open bank, 4 open of an open bank, 5 open before close-to-open delay, 6 open of another bank too soon, 7 column command to a closed bank, 8 column command before open-to-column delay, 9 close before open-to-close delay.
- R3: A read (row high, col low, wr high) or a write (row high, col low, wr low) gets code 7 if the addressed bank is closed. It gets code 8 if fewer than ACT_TO_CAS cycles have passed since that bank's open.
- R4: An open (row low, col high, wr high) to a bank that is already open gets code 4.
- R5: An open to a bank other than the one opened last gets code 6 if it comes fewer than ACT_TO_ACT cycles after the last open.
- R6: A close (row low, col high, wr low) with `cmd_ap` low targets only `cmd_bank`. With `cmd_ap` high it targets every bank, whatever `cmd_bank` holds. It gets code 9 if any targeted open bank was opened fewer than ACT_TO_PRE cycles earlier.
- R7: An open to a closed bank gets code 5 if fewer than PRE_TO_ACT cycles have passed since that bank was closed.
- R8: A read or write with `cmd_ap` high to an open bank schedules an internal close. The close happens in the first cycle that is at least BURST_CYC+CAS_CYC cycles after that command and at least ACT_TO_PRE cycles after the bank's open. The close-to-open delay counts from that cycle.
- R9: A mode set (row, col and wr all low) gets code 3 if any bank is open. `cmd_bank[0]` low selects the base register and high selects the extended register.
- R10: Any command other than a deselect or no-op gets code 2 if it comes fewer than MRS_GAP cycles after a mode set.
- R11: A base-register mode set with `cmd_dll` high makes any command in the following DLL_LOCK_CYC cycles get code 1. The same bit on an extended-register mode set has no effect.
- R12: When several rules fail, code 1 wins over code 2, and code 2 wins over any bank rule. The bank model is updated for every command, flagged or not.
- R13: A close aimed at a bank that is already closed is legal and does not restart that bank's close-to-open delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sel_n | input | 1 | Chip select, active low |
| cmd_row_n | input | 1 | Row strobe, active low |
| cmd_col_n | input | 1 | Column strobe, active low |
| cmd_wr_n | input | 1 | Write strobe, active low |
| cmd_bank | input | BA_W | Bank address |
| cmd_ap | input | 1 | All-bank close / auto-close address bit |
| cmd_dll | input | 1 | DLL-reset bit of the mode-set address |
| err_pulse | output | 1 | One-cycle violation flag |
| err_code | output | 4 | Violation cause, 0 when no violation |

## Verification
Two things can land in the same cycle. A scheduled auto-close can come due in the cycle where another command addresses that bank, and a lock or gap wait can overlap a command that also breaks a bank rule. The random phase mixes auto-close column commands with opens, closes and mode sets on random banks, so both overlaps occur often, and a directed run forces the gap/open-bank case. The reference model in the bench judges each command against the bank state before any close due in that cycle, and ranks the causes by the fixed priority.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_BST,
      CMD_PRE,
      CMD_MRS,
      CMD_MISC
   } cmd_e;

   typedef enum logic [3:0] {
      V_NONE     = 4'd0,
      V_DLL_LOCK = 4'd1,
      V_MRS_GAP  = 4'd2,
      V_MRS_OPEN = 4'd3,
      V_ACT_OPEN = 4'd4,
      V_ACT_RP   = 4'd5,
      V_ACT_RRD  = 4'd6,
      V_RW_IDLE  = 4'd7,
      V_RW_RCD   = 4'd8,
      V_PRE_RAS  = 4'd9
   } viol_e;

endpackage

// File: rtl/ddr_guard_decode.sv
module ddr_guard_decode
   import ddr_guard_pkg::*;
(
   input  logic sel_n,
   input  logic row_n,
   input  logic col_n,
   input  logic wr_n,
   output cmd_e cmd
);

   always_comb begin
      cmd = CMD_NONE;
      if (!sel_n) begin
         case ({row_n, col_n, wr_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b110:  cmd = CMD_BST;
            3'b010:  cmd = CMD_PRE;
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_MISC;
            default: cmd = CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/ddr_guard_bank.sv
module ddr_guard_bank #(
   parameter int ACT_TO_CAS = 3,
   parameter int ACT_TO_PRE = 6,
   parameter int PRE_TO_ACT = 3,
   parameter int AP_DELAY   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic do_act,
   input  logic do_pre,
   input  logic do_rw_ap,
   output logic is_open,
   output logic rcd_met,
   output logic ras_met,
   output logic rp_met
);

   localparam int MAX_A = (ACT_TO_CAS > ACT_TO_PRE) ? ACT_TO_CAS : ACT_TO_PRE;
   localparam int MAX_B = (PRE_TO_ACT > AP_DELAY) ? PRE_TO_ACT : AP_DELAY;
   localparam int MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int W     = $clog2(MAX_V + 1);

   logic [W-1:0] rcd_left, ras_left, rp_left, ap_left;
   logic         open_q, ap_pend;
   logic         ap_fire;

   assign ap_fire = open_q && ap_pend && (ap_left == '0) && (ras_left == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcd_left <= '0;
         ras_left <= '0;
         rp_left  <= '0;
         ap_left  <= '0;
         open_q   <= 1'b0;
         ap_pend  <= 1'b0;
      end else begin
         if (rcd_left != '0) rcd_left <= rcd_left - 1'b1;
         if (ras_left != '0) ras_left <= ras_left - 1'b1;
         if (rp_left  != '0) rp_left  <= rp_left  - 1'b1;
         if (ap_left  != '0) ap_left  <= ap_left  - 1'b1;
         if (do_act) begin
            open_q   <= 1'b1;
            ap_pend  <= 1'b0;
            rcd_left <= W'(ACT_TO_CAS - 1);
            ras_left <= W'(ACT_TO_PRE - 1);
         end else if (do_pre && open_q) begin
            open_q  <= 1'b0;
            ap_pend <= 1'b0;
            rp_left <= W'(PRE_TO_ACT - 1);
         end else if (ap_fire) begin
            open_q  <= 1'b0;
            ap_pend <= 1'b0;
            rp_left <= W'(PRE_TO_ACT - 1);
         end else if (do_rw_ap && open_q) begin
            ap_pend <= 1'b1;
            ap_left <= W'(AP_DELAY - 1);
         end
      end
   end

   assign is_open = open_q;
   assign rcd_met = (rcd_left == '0);
   assign ras_met = (ras_left == '0);
   assign rp_met  = (rp_left == '0);

endmodule

// File: rtl/ddr_guard_global.sv
module ddr_guard_global #(
   parameter int BA_W         = 2,
   parameter int ACT_TO_ACT   = 2,
   parameter int MRS_GAP      = 2,
   parameter int DLL_LOCK_CYC = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act_seen,
   input  logic [BA_W-1:0] bank,
   input  logic            mrs_seen,
   input  logic            dll_req,
   output logic            rrd_clash,
   output logic            mrd_met,
   output logic            dll_met
);

   localparam int W_R = $clog2(ACT_TO_ACT + 1);
   localparam int W_M = $clog2(MRS_GAP + 1);
   localparam int W_D = $clog2(DLL_LOCK_CYC + 1);

   logic [W_R-1:0]  rrd_left;
   logic [W_M-1:0]  mrd_left;
   logic [W_D-1:0]  dll_left;
   logic [BA_W-1:0] last_bank;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rrd_left  <= '0;
         mrd_left  <= '0;
         dll_left  <= '0;
         last_bank <= '0;
      end else begin
         if (rrd_left != '0) rrd_left <= rrd_left - 1'b1;
         if (mrd_left != '0) mrd_left <= mrd_left - 1'b1;
         if (dll_left != '0) dll_left <= dll_left - 1'b1;
         if (act_seen) begin
            rrd_left  <= W_R'(ACT_TO_ACT - 1);
            last_bank <= bank;
         end
         if (mrs_seen) mrd_left <= W_M'(MRS_GAP - 1);
         if (dll_req)  dll_left <= W_D'(DLL_LOCK_CYC);
      end
   end

   assign rrd_clash = (rrd_left != '0) && (bank != last_bank);
   assign mrd_met   = (mrd_left == '0);
   assign dll_met   = (dll_left == '0);

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
   import ddr_guard_pkg::*;
#(
   parameter int BANKS        = 4,
   parameter int ACT_TO_CAS   = 3,
   parameter int ACT_TO_ACT   = 2,
   parameter int PRE_TO_ACT   = 3,
   parameter int ACT_TO_PRE   = 6,
   parameter int MRS_GAP      = 2,
   parameter int DLL_LOCK_CYC = 200,
   parameter int BURST_CYC    = 2,
   parameter int CAS_CYC      = 2,
   parameter bit REG_OUT      = 1'b1,
   localparam int BA_W        = $clog2(BANKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_sel_n,
   input  logic            cmd_row_n,
   input  logic            cmd_col_n,
   input  logic            cmd_wr_n,
   input  logic [BA_W-1:0] cmd_bank,
   input  logic            cmd_ap,
   input  logic            cmd_dll,
   output logic            err_pulse,
   output logic [3:0]      err_code
);

   localparam int AP_DELAY = BURST_CYC + CAS_CYC;

   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (ACT_TO_CAS < 1 || ACT_TO_ACT < 1 || PRE_TO_ACT < 1 || ACT_TO_PRE < 1) begin : g_bad_bank_t
      $error("bank timing limits must be at least one cycle");
   end
   if (MRS_GAP < 1 || DLL_LOCK_CYC < 1 || AP_DELAY < 1) begin : g_bad_glob_t
      $error("global timing limits must be at least one cycle");
   end

   cmd_e             cmd;
   logic             real_cmd;
   logic [BANKS-1:0] open_vec, rcd_vec, ras_vec, rp_vec;
   logic             rrd_clash, mrd_met, dll_met;
   viol_e            v_next;

   ddr_guard_decode i_decode (
      .sel_n (cmd_sel_n),
      .row_n (cmd_row_n),
      .col_n (cmd_col_n),
      .wr_n  (cmd_wr_n),
      .cmd   (cmd)
   );

   assign real_cmd = (cmd != CMD_NONE);

   for (genvar i = 0; i < BANKS; i++) begin : g_bank
      logic hit;
      assign hit = (cmd_bank == BA_W'(i));
      ddr_guard_bank #(
         .ACT_TO_CAS (ACT_TO_CAS),
         .ACT_TO_PRE (ACT_TO_PRE),
         .PRE_TO_ACT (PRE_TO_ACT),
         .AP_DELAY   (AP_DELAY)
      ) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .do_act   ((cmd == CMD_ACT) && hit),
         .do_pre   ((cmd == CMD_PRE) && (cmd_ap || hit)),
         .do_rw_ap (((cmd == CMD_RD) || (cmd == CMD_WR)) && cmd_ap && hit),
         .is_open  (open_vec[i]),
         .rcd_met  (rcd_vec[i]),
         .ras_met  (ras_vec[i]),
         .rp_met   (rp_vec[i])
      );
   end

   ddr_guard_global #(
      .BA_W         (BA_W),
      .ACT_TO_ACT   (ACT_TO_ACT),
      .MRS_GAP      (MRS_GAP),
      .DLL_LOCK_CYC (DLL_LOCK_CYC)
   ) i_global (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_seen  (cmd == CMD_ACT),
      .bank      (cmd_bank),
      .mrs_seen  (cmd == CMD_MRS),
      .dll_req   ((cmd == CMD_MRS) && !cmd_bank[0] && cmd_dll),
      .rrd_clash (rrd_clash),
      .mrd_met   (mrd_met),
      .dll_met   (dll_met)
   );

   always_comb begin
      v_next = V_NONE;
      if (real_cmd) begin
         if (!dll_met) begin
            v_next = V_DLL_LOCK;
         end else if (!mrd_met) begin
            v_next = V_MRS_GAP;
         end else begin
            case (cmd)
               CMD_MRS: if (|open_vec) v_next = V_MRS_OPEN;
               CMD_ACT: begin
                  if (open_vec[cmd_bank])     v_next = V_ACT_OPEN;
                  else if (!rp_vec[cmd_bank]) v_next = V_ACT_RP;
                  else if (rrd_clash)         v_next = V_ACT_RRD;
               end
               CMD_RD, CMD_WR: begin
                  if (!open_vec[cmd_bank])     v_next = V_RW_IDLE;
                  else if (!rcd_vec[cmd_bank]) v_next = V_RW_RCD;
               end
               CMD_PRE: begin
                  if (cmd_ap ? (|(open_vec & ~ras_vec))
                             : (open_vec[cmd_bank] && !ras_vec[cmd_bank]))
                     v_next = V_PRE_RAS;
               end
               default: v_next = V_NONE;
            endcase
         end
      end
   end

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            err_pulse <= 1'b0;
            err_code  <= 4'd0;
         end else begin
            err_pulse <= (v_next != V_NONE);
            err_code  <= v_next;
         end
      end
   end else begin : g_out_comb
      assign err_pulse = (v_next != V_NONE);
      assign err_code  = v_next;
   end

endmodule

// File: rtl/ddr_cmd_guard_chk.sv
module ddr_cmd_guard_chk #(
   parameter int BA_W    = 2,
   parameter bit REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_sel_n,
   input logic            cmd_row_n,
   input logic            cmd_col_n,
   input logic            cmd_wr_n,
   input logic [BA_W-1:0] cmd_bank,
   input logic            cmd_dll,
   input logic            err_pulse,
   input logic [3:0]      err_code
);

   logic real_now, mrs_now;
   logic mrs_q, dll_q, quiet_q, gap_hit_q, lock_hit_q;
   logic gap_hit, lock_hit;
   logic seen_quiet, seen_gap, seen_lock;

   assign real_now = !cmd_sel_n && !(cmd_row_n && cmd_col_n && cmd_wr_n);
   assign mrs_now  = !cmd_sel_n && !cmd_row_n && !cmd_col_n && !cmd_wr_n;
   assign gap_hit  = mrs_q && real_now;
   assign lock_hit = dll_q && real_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mrs_q      <= 1'b0;
         dll_q      <= 1'b0;
         quiet_q    <= 1'b1;
         gap_hit_q  <= 1'b0;
         lock_hit_q <= 1'b0;
      end else begin
         mrs_q      <= mrs_now;
         dll_q      <= mrs_now && !cmd_bank[0] && cmd_dll;
         quiet_q    <= !real_now;
         gap_hit_q  <= gap_hit;
         lock_hit_q <= lock_hit;
      end
   end

   assign seen_quiet = REG_OUT ? quiet_q    : !real_now;
   assign seen_gap   = REG_OUT ? gap_hit_q  : gap_hit;
   assign seen_lock  = REG_OUT ? lock_hit_q : lock_hit;

   // R2: flag and code agree
   p_flag_has_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_code != 4'd0));
   p_quiet_code_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !err_pulse |-> (err_code == 4'd0));
   p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err_code <= 4'd9);
   // R1: no-op and deselect never flagged
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      seen_quiet |-> !err_pulse);
   // R10: command right after a mode set is flagged
   p_mrs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      seen_gap |-> (err_pulse && (err_code == 4'd1 || err_code == 4'd2)));
   // R11, R12: command right after a DLL-reset mode set reports the lock wait
   p_dll_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      seen_lock |-> (err_pulse && err_code == 4'd1));

endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk #(
   .BA_W    (BA_W),
   .REG_OUT (REG_OUT)
) i_guard_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_sel_n (cmd_sel_n),
   .cmd_row_n (cmd_row_n),
   .cmd_col_n (cmd_col_n),
   .cmd_wr_n  (cmd_wr_n),
   .cmd_bank  (cmd_bank),
   .cmd_dll   (cmd_dll),
   .err_pulse (err_pulse),
   .err_code  (err_code)
);

// File: tb/test_ddr_cmd_guard.sv
module test_ddr_cmd_guard;

   localparam int NB    = 4;
   localparam int L_RCD = 3;
   localparam int L_RRD = 2;
   localparam int L_RP  = 3;
   localparam int L_RAS = 6;
   localparam int L_MRD = 2;
   localparam int L_DLL = 200;
   localparam int L_AP  = 4;

   // bench command kinds
   localparam int K_NOP = 0, K_DES = 1, K_ACT = 2, K_RD = 3, K_WR = 4;
   localparam int K_BST = 5, K_PRE = 6, K_MRS = 7, K_REF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b0, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1;
   logic [1:0] bank = 2'd0;
   logic       ap = 1'b0, dll = 1'b0;
   logic       err_pulse;
   logic [3:0] err_code;

   always #4 clk = ~clk;

   ddr_cmd_guard i_ddr_cmd_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_sel_n (sel_n),
      .cmd_row_n (row_n),
      .cmd_col_n (col_n),
      .cmd_wr_n  (wr_n),
      .cmd_bank  (bank),
      .cmd_ap    (ap),
      .cmd_dll   (dll),
      .err_pulse (err_pulse),
      .err_code  (err_code)
   );

   int    n_chk = 0, n_fail = 0, cyc = 0;
   bit    done = 0, have_prev = 0;
   int    exp_code = 0;
   string exp_tag = "R2";

   // reference model state
   bit m_open[NB], m_pend[NB];
   int m_act[NB], m_pre[NB], m_apdue[NB];
   int m_lastact = -1000, m_lastb = 0, m_mrs = -1000, m_dll_until = -1;

   function automatic string code_tag(int c);
      case (c)
         1: return "R11";
         2: return "R10";
         3: return "R9";
         4: return "R4";
         5: return "R7";
         6: return "R5";
         7, 8: return "R3";
         9: return "R6";
         default: return "R2";
      endcase
   endfunction

   function automatic int predict(int kind, int b, bit a, bit d);
      int  t = cyc;
      int  code = 0;
      bit  realc = !(kind == K_NOP || kind == K_DES);
      bit  fire[NB];
      bit  any_open = 0, ras_bad = 0;
      for (int i = 0; i < NB; i++) begin
         fire[i] = m_open[i] && m_pend[i] && t >= m_apdue[i] && t >= m_act[i] + L_RAS;
         any_open |= m_open[i];
         if (m_open[i] && t - m_act[i] < L_RAS && (a || i == b)) ras_bad = 1;
      end
      if (realc) begin
         if (t <= m_dll_until) code = 1;
         else if (t - m_mrs < L_MRD) code = 2;
         else case (kind)
            K_MRS: if (any_open) code = 3;
            K_ACT: begin
               if (m_open[b]) code = 4;
               else if (t - m_pre[b] < L_RP) code = 5;
               else if (b != m_lastb && t - m_lastact < L_RRD) code = 6;
            end
            K_RD, K_WR: begin
               if (!m_open[b]) code = 7;
               else if (t - m_act[b] < L_RCD) code = 8;
            end
            K_PRE: if (ras_bad) code = 9;
            default: code = 0;
         endcase
      end
      for (int i = 0; i < NB; i++) begin
         if (kind == K_ACT && b == i) begin
            m_open[i] = 1; m_pend[i] = 0; m_act[i] = t;
         end else if (kind == K_PRE && (a || b == i) && m_open[i]) begin
            m_open[i] = 0; m_pend[i] = 0; m_pre[i] = t;
         end else if (fire[i]) begin
            m_open[i] = 0; m_pend[i] = 0; m_pre[i] = t;
         end else if ((kind == K_RD || kind == K_WR) && a && b == i && m_open[i]) begin
            m_pend[i] = 1; m_apdue[i] = t + L_AP;
         end
      end
      if (kind == K_ACT) begin m_lastact = t; m_lastb = b; end
      if (kind == K_MRS) begin
         m_mrs = t;
         if ((b % 2) == 0 && d) m_dll_until = t + L_DLL;
      end
      return code;
   endfunction

   task automatic check_prev();
      string tg;
      if (!have_prev) return;
      n_chk++;
      tg = (exp_code != 0) ? code_tag(exp_code) : exp_tag;
      if (err_pulse !== (exp_code != 0) || err_code !== 4'(exp_code)) begin
         n_fail++;
         $display("FAIL %s cycle %0d: flag=%0b code=%0d expected flag=%0b code=%0d",
                  tg, cyc - 1, err_pulse, err_code, exp_code != 0, exp_code);
      end
   endtask

   task automatic issue(int kind, int b, bit a, bit d, string tag);
      @(negedge clk);
      check_prev();
      sel_n = 1'b0; bank = 2'(b); ap = a; dll = d;
      case (kind)
         K_NOP: {row_n, col_n, wr_n} = 3'b111;
         K_DES: begin sel_n = 1'b1; {row_n, col_n, wr_n} = 3'b011; end
         K_ACT: {row_n, col_n, wr_n} = 3'b011;
         K_RD:  {row_n, col_n, wr_n} = 3'b101;
         K_WR:  {row_n, col_n, wr_n} = 3'b100;
         K_BST: {row_n, col_n, wr_n} = 3'b110;
         K_PRE: {row_n, col_n, wr_n} = 3'b010;
         K_MRS: {row_n, col_n, wr_n} = 3'b000;
         default: {row_n, col_n, wr_n} = 3'b001;
      endcase
      exp_code  = predict(kind, b, a, d);
      exp_tag   = tag;
      have_prev = 1;
      cyc++;
   endtask

   task automatic nops(int n);
      for (int k = 0; k < n; k++) issue(K_NOP, 0, 0, 0, "R1");
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NB; i++) begin
         m_open[i] = 0; m_pend[i] = 0; m_act[i] = -1000; m_pre[i] = -1000; m_apdue[i] = 0;
      end
      void'($urandom(32'h0000_5eed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      n_chk++;
      if (err_pulse !== 1'b0 || err_code !== 4'd0) begin
         n_fail++;
         $display("FAIL R2 reset: flag=%0b code=%0d expected flag=0 code=0", err_pulse, err_code);
      end
      // R1: deselected open leaves bank closed, so the read is code 7
      issue(K_DES, 0, 0, 0, "R1");
      issue(K_RD, 0, 0, 0, "R1");
      // R3: open-to-column delay
      issue(K_ACT, 0, 0, 0, "R3");
      issue(K_RD, 0, 0, 0, "R3");
      nops(1);
      issue(K_WR, 0, 0, 0, "R3");
      // R5 and R4: bank-to-bank gap, reopen of an open bank
      issue(K_ACT, 2, 0, 0, "R5");
      issue(K_ACT, 3, 0, 0, "R5");
      issue(K_ACT, 2, 0, 0, "R4");
      // R6 then R7: early close, early reopen
      issue(K_PRE, 2, 0, 0, "R6");
      issue(K_ACT, 2, 0, 0, "R7");
      // R9 then R12: mode set with open banks, then gap wins over bank rules
      issue(K_MRS, 0, 0, 0, "R9");
      issue(K_ACT, 1, 0, 0, "R12");
      nops(8);
      issue(K_PRE, 0, 1, 0, "R6");
      // R13: close of a closed bank does not restart its delay
      issue(K_PRE, 1, 0, 0, "R13");
      nops(1);
      issue(K_ACT, 1, 0, 0, "R13");
      // R8: auto-close, burst-limited case (early then on-time reopen)
      nops(2);
      issue(K_RD, 1, 1, 0, "R8");
      nops(5);
      issue(K_ACT, 1, 0, 0, "R8");
      nops(2);
      issue(K_WR, 1, 1, 0, "R8");
      nops(6);
      issue(K_ACT, 1, 0, 0, "R8");
      // R8: open-to-close limited case
      issue(K_RD, 1, 1, 0, "R8");
      nops(6);
      issue(K_ACT, 1, 0, 0, "R8");
      nops(6);
      issue(K_PRE, 0, 1, 0, "R6");
      // R9 and R11: extended-register mode set ignores the DLL bit
      nops(2);
      issue(K_MRS, 1, 0, 1, "R9");
      nops(1);
      issue(K_ACT, 0, 0, 0, "R11");
      nops(6);
      issue(K_PRE, 0, 1, 0, "R6");
      // R11: base-register DLL reset lock window edges
      issue(K_MRS, 0, 0, 1, "R11");
      nops(1);
      issue(K_BST, 0, 0, 0, "R11");
      nops(197);
      issue(K_REF, 0, 0, 0, "R11");
      issue(K_ACT, 2, 0, 0, "R11");
      // random phase
      for (int n = 0; n < 3000; n++) begin
         int r = int'($urandom % 16);
         int b = int'($urandom % 4);
         bit a = 1'($urandom % 2);
         bit d = ($urandom % 32) == 0;
         int k;
         if (r < 3 || r == 15) k = K_NOP;
         else if (r == 3) k = K_DES;
         else if (r < 7) k = K_ACT;
         else if (r < 9) k = K_RD;
         else if (r == 9) k = K_WR;
         else if (r == 10) k = K_BST;
         else if (r < 13) k = K_PRE;
         else if (r == 13) k = K_MRS;
         else k = K_REF;
         issue(k, b, a, d, "R12");
      end
      issue(K_NOP, 0, 0, 0, "R1");
      @(negedge clk);
      check_prev();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule